// File: doc/BRIEF.md
# Ping-Pong Feature Map Store with Preset Border Padding

This block keeps one layer's output feature map so that the following layer can read it as many times as it needs. Two equal banks work as a ping-pong pair: the producing layer fills one while the consuming layer streams from the other. Each bank holds the padded map, which has one extra cell on every side of the interior. A frame swap hands the freshly filled bank to the reader and the read bank back to the writer.

Padding costs no run-time cycles. Right after reset, one sweep over both banks writes the border cells with a checkerboard of +1 and -1 codes and clears the interior. The producer then sends only interior pixels in raster order. The block steers each one to its padded address, so the border is never touched again. The consumer always reads the whole padded map in raster order, starting from cell 0.

Top module: `fmb_pingpong`

## Requirements
- R1: After reset is released, `init_busy` stays high for exactly PAD_W*PAD_H cycles (PAD_W = MAP_W+2, PAD_H = MAP_H+2), then falls and never rises again until the next reset. During that sweep both banks are preset.
- R2: After the preset, a border cell at padded row r, column c holds all ones (+1) when r+c is even and all zeros (-1) when r+c is odd. Interior cells hold zero.
- R3: Accepted pixels land on interior cells in raster order. The first goes to padded address PAD_W+1. The address then rises by 1 within an interior row and by 3 from the last pixel of one row to the first of the next, stepping over the two border cells.
- R4: Writes never change a border cell. Borders keep their preset values across frames and swaps.
- R5: `frame_full` rises in the cycle after the MAP_W*MAP_H-th accepted pixel. While it is high, `wr_valid` is ignored and `frame_full` stays high until a swap.
- R6: `swap_req` takes effect only when `frame_full` is high. A swap toggles `wr_bank` and `rd_bank` in the same cycle, so they are always opposite. It also clears `frame_full` and returns both the write address and the read address to their start values.
- R7: Each accepted `rd_req` returns the cell at the read pointer on `rd_data`, with `rd_valid` high, one cycle later. The pointer starts at 0, advances in raster order and wraps from PAD_W*PAD_H-1 back to 0.
- R8: While `init_busy` is high, `wr_valid`, `rd_req` and `swap_req` have no effect.
- R9: In reset, `wr_bank`=0, `rd_bank`=1, `frame_full`=0, `rd_valid`=0 and `init_busy`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Interior pixel offered by the producer |
| wr_data | input | DATA_W | Interior pixel value |
| rd_req | input | 1 | Read the next padded cell |
| swap_req | input | 1 | Exchange the write and read banks |
| rd_data | output | DATA_W | Cell value, one cycle after the request |
| rd_valid | output | 1 | `rd_data` holds a requested cell |
| init_busy | output | 1 | Border preset sweep in progress |
| frame_full | output | 1 | Write bank holds a complete interior frame |
| wr_bank | output | 1 | Bank currently being filled |
| rd_bank | output | 1 | Bank currently being read |

## Verification
The assertions take for granted that the controller raises `swap_req` only after checking `frame_full`, and that a consumer may pulse `rd_req` in any cycle. When the request comes at other times, the properties only require that the banks stay put. The stimulus drives every input to its active level throughout the preset sweep, to show that nothing leaks through while `init_busy` is high. It also offers extra pixels after a full frame and a swap request in the middle of a frame. In every other case inputs change only on the falling edge and follow the producer and consumer order that the requirements describe.

// File: rtl/fmb_pkg.sv
package fmb_pkg;
  // Padding code for a border cell: +1 (all ones) on even row+col parity,
  // -1 (all zeros) on odd parity.
  function automatic logic pad_bit(input logic row_lsb, input logic col_lsb);
    return ~(row_lsb ^ col_lsb);
  endfunction
endpackage

// File: rtl/fmb_init_seq.sv
module fmb_init_seq #(
  parameter int PAD_W = 6,
  parameter int PAD_H = 6,
  parameter int AW    = 6
) (
  input  logic          clk,
  input  logic          rst,
  output logic          busy,
  output logic [AW-1:0] addr,
  output logic          is_border,
  output logic          even_cell
);
  localparam int RW = $clog2(PAD_H);
  localparam int CW = $clog2(PAD_W);

  logic [RW-1:0] row;
  logic [CW-1:0] col;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b1;
      row  <= '0;
      col  <= '0;
      addr <= '0;
    end else if (busy) begin
      addr <= addr + AW'(1);
      if (col == CW'(PAD_W - 1)) begin
        col <= '0;
        if (row == RW'(PAD_H - 1)) busy <= 1'b0;
        else                       row  <= row + RW'(1);
      end else begin
        col <= col + CW'(1);
      end
    end
  end

  assign is_border = (row == '0) || (row == RW'(PAD_H - 1)) ||
                     (col == '0) || (col == CW'(PAD_W - 1));
  assign even_cell = fmb_pkg::pad_bit(row[0], col[0]);
endmodule

// File: rtl/fmb_wr_addr.sv
module fmb_wr_addr #(
  parameter int MAP_W = 4,
  parameter int MAP_H = 4,
  parameter int PAD_W = 6,
  parameter int AW    = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  input  logic          step,
  output logic [AW-1:0] addr,
  output logic          done
);
  localparam int NPIX  = MAP_W * MAP_H;
  localparam int CNTW  = $clog2(NPIX + 1);
  localparam int COLW  = $clog2(MAP_W + 1);
  localparam int FIRST = PAD_W + 1;

  logic [CNTW-1:0] cnt;
  logic [COLW-1:0] col;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      addr <= AW'(FIRST);
      col  <= '0;
      cnt  <= '0;
      done <= 1'b0;
    end else if (step && !done) begin
      cnt  <= cnt + CNTW'(1);
      done <= (cnt == CNTW'(NPIX - 1));
      if (col == COLW'(MAP_W - 1)) begin
        col  <= '0;
        addr <= addr + AW'(3);
      end else begin
        col  <= col + COLW'(1);
        addr <= addr + AW'(1);
      end
    end
  end
endmodule

// File: rtl/fmb_bank.sv
module fmb_bank #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 36,
  parameter int AW     = 6
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/fmb_pingpong.sv
module fmb_pingpong #(
  parameter int DATA_W = 8,
  parameter int MAP_W  = 4,
  parameter int MAP_H  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_req,
  input  logic              swap_req,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              init_busy,
  output logic              frame_full,
  output logic              wr_bank,
  output logic              rd_bank
);
  localparam int PAD_W = MAP_W + 2;
  localparam int PAD_H = MAP_H + 2;
  localparam int DEPTH = PAD_W * PAD_H;
  localparam int AW    = $clog2(DEPTH);

  logic [AW-1:0]     init_addr;
  logic              init_border;
  logic              init_even;
  logic [DATA_W-1:0] init_word;
  logic [AW-1:0]     wr_addr;
  logic [AW-1:0]     rd_ptr;
  logic              wr_fire;
  logic              rd_fire;
  logic              swap_fire;
  logic              rd_sel_q;
  logic [DATA_W-1:0] bank_q [2];

  assign wr_fire   = wr_valid && !init_busy && !frame_full;
  assign rd_fire   = rd_req && !init_busy;
  assign swap_fire = swap_req && frame_full && !init_busy;
  assign init_word = init_border ? {DATA_W{init_even}} : '0;

  fmb_init_seq #(.PAD_W(PAD_W), .PAD_H(PAD_H), .AW(AW)) u_init (
    .clk       (clk),
    .rst       (rst),
    .busy      (init_busy),
    .addr      (init_addr),
    .is_border (init_border),
    .even_cell (init_even)
  );

  fmb_wr_addr #(.MAP_W(MAP_W), .MAP_H(MAP_H), .PAD_W(PAD_W), .AW(AW)) u_wgen (
    .clk     (clk),
    .rst     (rst),
    .restart (swap_fire),
    .step    (wr_fire),
    .addr    (wr_addr),
    .done    (frame_full)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_bank  <= 1'b0;
      rd_bank  <= 1'b1;
      rd_ptr   <= '0;
      rd_valid <= 1'b0;
      rd_sel_q <= 1'b1;
    end else begin
      rd_valid <= rd_fire;
      if (rd_fire) rd_sel_q <= rd_bank;
      if (swap_fire) begin
        wr_bank <= ~wr_bank;
        rd_bank <= ~rd_bank;
        rd_ptr  <= '0;
      end else if (rd_fire) begin
        rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + AW'(1);
      end
    end
  end

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic              we_b;
    logic [AW-1:0]     waddr_b;
    logic [DATA_W-1:0] wdata_b;

    assign we_b    = init_busy || (wr_fire && (wr_bank == 1'(b)));
    assign waddr_b = init_busy ? init_addr : wr_addr;
    assign wdata_b = init_busy ? init_word : wr_data;

    fmb_bank #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_mem (
      .clk   (clk),
      .we    (we_b),
      .waddr (waddr_b),
      .wdata (wdata_b),
      .raddr (rd_ptr),
      .rdata (bank_q[b])
    );
  end

  assign rd_data = bank_q[rd_sel_q];
endmodule

// File: rtl/fmb_pingpong_chk.sv
module fmb_pingpong_chk (
  input logic clk,
  input logic rst,
  input logic rd_req,
  input logic swap_req,
  input logic init_busy,
  input logic frame_full,
  input logic wr_bank,
  input logic rd_bank,
  input logic rd_valid
);
  // R1
  busy_no_return_chk: assert property (@(posedge clk) disable iff (rst)
    !init_busy |=> !init_busy);

  // R5
  full_holds_chk: assert property (@(posedge clk) disable iff (rst)
    frame_full && !swap_req |=> frame_full);

  // R6
  banks_opposite_chk: assert property (@(posedge clk) disable iff (rst)
    wr_bank != rd_bank);

  // R6
  swap_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_bank != $past(wr_bank)) |-> $past(frame_full && swap_req));

  // R6
  swap_clears_chk: assert property (@(posedge clk) disable iff (rst)
    frame_full && swap_req |=> !frame_full);

  // R7
  rd_latency_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid == $past(rd_req && !init_busy));

  // R8
  quiet_when_busy_chk: assert property (@(posedge clk) disable iff (rst)
    init_busy |-> !frame_full && !rd_valid);
endmodule

bind fmb_pingpong fmb_pingpong_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .rd_req     (rd_req),
  .swap_req   (swap_req),
  .init_busy  (init_busy),
  .frame_full (frame_full),
  .wr_bank    (wr_bank),
  .rd_bank    (rd_bank),
  .rd_valid   (rd_valid)
);

// File: tb/fmb_pingpong_test.sv
`timescale 1ns/1ps
module fmb_pingpong_test;
  localparam int DW    = 8;
  localparam int MW    = 4;
  localparam int MH    = 4;
  localparam int PW    = MW + 2;
  localparam int PH    = MH + 2;
  localparam int DEPTH = PW * PH;
  localparam int NPIX  = MW * MH;

  // stimulus pixel and the padded address it must reach (R3)
  localparam logic [DW-1:0] PIX [NPIX] = '{
    8'h3c, 8'h5a, 8'h81, 8'h7e, 8'h11, 8'h22, 8'h44, 8'h88,
    8'hc3, 8'h96, 8'h69, 8'h0f, 8'hf0, 8'h18, 8'h24, 8'h42};
  localparam int EXP_ADDR [NPIX] = '{
    7, 8, 9, 10, 13, 14, 15, 16, 19, 20, 21, 22, 25, 26, 27, 28};

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_valid = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          rd_req = 1'b0;
  logic          swap_req = 1'b0;
  logic [DW-1:0] rd_data;
  logic          rd_valid, init_busy, frame_full, wr_bank, rd_bank;

  int checks = 0;
  int failures = 0;
  logic [DW-1:0] expm [2][DEPTH];

  always #4 clk = ~clk;

  fmb_pingpong #(.DATA_W(DW), .MAP_W(MW), .MAP_H(MH)) uut (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_data(wr_data),
    .rd_req(rd_req), .swap_req(swap_req), .rd_data(rd_data),
    .rd_valid(rd_valid), .init_busy(init_busy), .frame_full(frame_full),
    .wr_bank(wr_bank), .rd_bank(rd_bank));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic is_border(input int a);
    int r = a / PW;
    int c = a % PW;
    return (r == 0) || (r == PH - 1) || (c == 0) || (c == PW - 1);
  endfunction

  task automatic preset_model();
    for (int b = 0; b < 2; b++)
      for (int a = 0; a < DEPTH; a++)
        expm[b][a] = (is_border(a) && (((a / PW) + (a % PW)) % 2 == 0)) ? '1 : '0;
  endtask

  // reads n cells starting at padded address start; called and returns at negedge
  task automatic read_frame(input int bank, input int n, input int start, input string btag);
    rd_req = 1'b1;
    for (int k = 0; k < n; k++) begin
      int a = (start + k) % DEPTH;
      @(negedge clk);
      if (k == n - 1) rd_req = 1'b0;
      chk(rd_valid === 1'b1, "R7 rd_valid", int'(rd_valid), 1);
      chk(rd_data === expm[bank][a], is_border(a) ? btag : "R3 interior",
          int'(rd_data), int'(expm[bank][a]));
    end
    @(negedge clk);
    chk(rd_valid === 1'b0, "R7 no request", int'(rd_valid), 0);
  endtask

  task automatic write_pixels(input int bank, input int first, input int n, input logic [DW-1:0] xr);
    wr_valid = 1'b1;
    for (int i = first; i < first + n; i++) begin
      wr_data = PIX[i] ^ xr;
      expm[bank][EXP_ADDR[i]] = PIX[i] ^ xr;
      @(negedge clk);
      chk(frame_full === (i == NPIX - 1), "R5 frame_full", int'(frame_full), int'(i == NPIX - 1));
    end
    wr_valid = 1'b0;
  endtask

  task automatic do_swap();
    swap_req = 1'b1;
    @(negedge clk);
    swap_req = 1'b0;
  endtask

  task automatic wait_init(output int cnt);
    bit leak = 0;
    cnt = 0;
    while (init_busy === 1'b1) begin
      cnt++;
      if (rd_valid !== 1'b0 || frame_full !== 1'b0) leak = 1;
      @(negedge clk);
    end
    wr_valid = 1'b0; rd_req = 1'b0; swap_req = 1'b0;
    chk(!leak, "R8 inputs ignored while busy", int'(leak), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int cnt;
    preset_model();
    // every input active across reset and the preset sweep (R8)
    wr_valid = 1'b1; rd_req = 1'b1; swap_req = 1'b1; wr_data = 8'hee;
    repeat (3) @(negedge clk);
    chk(init_busy === 1'b1, "R9 busy in reset", int'(init_busy), 1);
    chk(wr_bank === 1'b0 && rd_bank === 1'b1, "R9 banks in reset", {wr_bank, rd_bank}, 1);
    chk(frame_full === 1'b0 && rd_valid === 1'b0, "R9 flags in reset", {frame_full, rd_valid}, 0);
    rst = 1'b0;
    wait_init(cnt);
    chk(cnt == DEPTH, "R1 busy length", cnt, DEPTH);
    chk(wr_bank === 1'b0 && rd_bank === 1'b1, "R8 swap ignored while busy", {wr_bank, rd_bank}, 1);

    // preset pattern in read bank, with wrap back to cell 0 (R2, R7)
    read_frame(1, DEPTH + 1, 0, "R2 border preset");

    // table walk: full frame into bank 0 (R3, R5)
    write_pixels(0, 0, NPIX, 8'h00);
    // extra pixels after full are ignored (R5)
    wr_valid = 1'b1; wr_data = 8'h55;
    repeat (3) @(negedge clk);
    wr_valid = 1'b0;
    chk(frame_full === 1'b1, "R5 full holds", int'(frame_full), 1);
    do_swap();
    chk(wr_bank === 1'b1 && rd_bank === 1'b0, "R6 swap toggles both", {wr_bank, rd_bank}, 2);
    chk(frame_full === 1'b0, "R6 swap clears full", int'(frame_full), 0);
    // read pointer back at 0 after swap (R6), borders untouched (R4)
    read_frame(0, DEPTH, 0, "R4 border kept");

    // half frame, then an early swap that must be ignored (R6)
    write_pixels(1, 0, NPIX / 2, 8'ha5);
    do_swap();
    chk(wr_bank === 1'b1 && rd_bank === 1'b0, "R6 early swap ignored", {wr_bank, rd_bank}, 2);
    write_pixels(1, NPIX / 2, NPIX / 2, 8'ha5);
    do_swap();
    chk(wr_bank === 1'b0 && rd_bank === 1'b1, "R6 second swap", {wr_bank, rd_bank}, 1);
    read_frame(1, DEPTH, 0, "R4 border kept");

    // reset mid-stream: state returns and both banks preset again (R1, R9)
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk(wr_bank === 1'b0 && rd_bank === 1'b1 && init_busy === 1'b1,
        "R9 reset again", {init_busy, wr_bank, rd_bank}, 5);
    rst = 1'b0;
    wait_init(cnt);
    chk(cnt == DEPTH, "R1 busy length again", cnt, DEPTH);
    preset_model();
    read_frame(1, DEPTH, 0, "R2 border preset");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule